// File: doc/BRIEF.md
# Watchdog Timer with Pre-Reset Interrupt

This block is a supervision counter that software must restart at regular intervals. While enabled it counts system clock cycles. A 2-bit select input picks one of four timeout lengths. If the count reaches the selected length without a restart, the block raises an interrupt. Software then has a fixed grace window to react. If that window also ends without a restart, the block drives a reset pulse of fixed length toward the rest of the system. It also sets a sticky cause flag, so that software can later tell that the last reset came from the watchdog.

The timeout lengths, the grace window and the pulse length are parameters. The defaults give timeouts of 2^12, 2^15, 2^18 and 2^21 cycles, a grace window of 512 cycles and a reset pulse of 4 cycles. The watchdog's own reset output never clears the cause flag. Only the clear strobe or the block's asynchronous power-on reset clears it.

Top module: `watchdog_timer`

## Requirements
- R1: With the watchdog enabled, the interrupt rises on the 2^(12 + 3*sel) -th clock edge after a restart edge, where sel is the select value: 00 gives 2^12, 01 gives 2^15, 10 gives 2^18 and 11 gives 2^21. When counting starts from the disabled state instead of from a restart, the first enabled edge counts as edge 1.
- R2: Once raised, the interrupt stays high until a restart, until the reset pulse starts, or until the block is disabled.
- R3: If no restart arrives, the reset output rises on the 512th clock edge after the edge that raised the interrupt, and the interrupt falls on that same edge.
- R4: The reset output stays high for exactly 4 clock cycles while the block stays enabled.
- R5: The cause flag goes high on the edge where the reset pulse starts. The pulse itself does not clear it, and it stays high afterwards.
- R6: A clear strobe drops the cause flag on the next edge. If the flag is being set on that same edge, setting wins.
- R7: A restart strobe clears the count, the interrupt and the grace window, so a full timeout starts over. During a reset pulse a restart has no effect and the pulse runs to its end.
- R8: While the enable input is low, the count is held at zero, and the interrupt and reset outputs are low from the next edge on. Dropping the enable cuts short any pending interrupt or pulse.
- R9: When a reset pulse ends, counting starts again from zero without any restart, so a further interrupt follows one full timeout later.
- R10: While the asynchronous active-low reset input is asserted, the interrupt, reset and cause flag outputs are all low.
- R11: The select input is compared on every cycle. If the select is changed so that the count already equals or exceeds the new timeout minus one, the interrupt rises on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| en_i | input | 1 | Watchdog enable |
| sel_i | input | 2 | Timeout select code |
| kick_i | input | 1 | Restart strobe from software |
| clr_flag_i | input | 1 | Clear strobe for the cause flag |
| irq_o | output | 1 | Watchdog interrupt, high from timeout until restart or reset |
| wdt_rst_o | output | 1 | System reset pulse |
| cause_o | output | 1 | Sticky watchdog-reset cause flag |

## Verification
The bound checker covers the rules that hold on every cycle. It checks that every reset pulse is preceded by an interrupt and is exactly four cycles long when not cut short. It checks that the interrupt and the reset are never high together, that disabling silences both outputs, and that a restart outside a pulse drops the interrupt. It also checks that the cause flag is raised with every pulse and only falls after a clear strobe. The exact timeout lengths can only be shown by the bench's timed scenarios, since they depend on the select value and on when the last restart happened. The same holds for the grace-window length, for the restart being ignored during a pulse, for counting resuming after a pulse, and for a lowered select expiring at once.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        PH_RUN   = 2'd0,
        PH_GRACE = 2'd1,
        PH_PULSE = 2'd2
    } wdt_phase_e;

    function automatic int unsigned wdt_max3(input int unsigned a,
                                             input int unsigned b,
                                             input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/wdt_limit_sel.sv
module wdt_limit_sel #(
    parameter int unsigned BASE_EXP = 12,
    parameter int unsigned STEP_EXP = 3,
    parameter int unsigned CNT_W    = 22
) (
    input  logic [1:0]       sel_i,
    output logic [CNT_W-1:0] term_o
);
    localparam int unsigned N_SEL = 4;

    logic [CNT_W-1:0] term_tab [N_SEL];

    // terminal count = interval length minus one, one entry per select code
    for (genvar g = 0; g < N_SEL; g++) begin : g_tab
        localparam longint unsigned LEN = 64'd1 << (BASE_EXP + g * STEP_EXP);
        assign term_tab[g] = CNT_W'(LEN - 64'd1);
    end

    assign term_o = term_tab[sel_i];

endmodule

// File: rtl/wdt_cause_flag.sv
module wdt_cause_flag (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;   // a new cause outranks a clear
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flag_q <= 1'b0;
        else         flag_q <= flag_d;
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/watchdog_timer.sv
module watchdog_timer #(
    parameter int unsigned BASE_EXP     = 12,
    parameter int unsigned STEP_EXP     = 3,
    parameter int unsigned GRACE_CYCLES = 512,
    parameter int unsigned PULSE_CYCLES = 4
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       en_i,
    input  logic [1:0] sel_i,
    input  logic       kick_i,
    input  logic       clr_flag_i,
    output logic       irq_o,
    output logic       wdt_rst_o,
    output logic       cause_o
);
    import wdt_pkg::*;

    localparam int unsigned MAX_EXP = BASE_EXP + 3 * STEP_EXP;
    localparam int unsigned CNT_W   = wdt_max3(MAX_EXP, $clog2(GRACE_CYCLES),
                                               $clog2(PULSE_CYCLES)) + 1;
    localparam logic [CNT_W-1:0] GRACE_LAST = CNT_W'(GRACE_CYCLES - 1);
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYCLES - 1);

    typedef struct packed {
        wdt_phase_e       phase;
        logic [CNT_W-1:0] cnt;
        logic             irq;
        logic             rst;
    } wdt_state_t;

    wdt_state_t       st_d, st_q;
    logic [CNT_W-1:0] term;
    logic             cause_set;

    wdt_limit_sel #(
        .BASE_EXP (BASE_EXP),
        .STEP_EXP (STEP_EXP),
        .CNT_W    (CNT_W)
    ) u_limit (
        .sel_i  (sel_i),
        .term_o (term)
    );

    always_comb begin
        st_d      = st_q;
        cause_set = 1'b0;
        if (!en_i) begin
            st_d.phase = PH_RUN;
            st_d.cnt   = '0;
            st_d.irq   = 1'b0;
            st_d.rst   = 1'b0;
        end else if (st_q.phase == PH_PULSE) begin
            // pulse runs to completion, restarts are ignored here
            if (st_q.cnt == PULSE_LAST) begin
                st_d.phase = PH_RUN;
                st_d.cnt   = '0;
                st_d.rst   = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (kick_i) begin
            st_d.phase = PH_RUN;
            st_d.cnt   = '0;
            st_d.irq   = 1'b0;
        end else if (st_q.phase == PH_RUN) begin
            if (st_q.cnt >= term) begin
                st_d.phase = PH_GRACE;
                st_d.cnt   = '0;
                st_d.irq   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            if (st_q.cnt == GRACE_LAST) begin
                st_d.phase = PH_PULSE;
                st_d.cnt   = '0;
                st_d.irq   = 1'b0;
                st_d.rst   = 1'b1;
                cause_set  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.phase <= PH_RUN;
            st_q.cnt   <= '0;
            st_q.irq   <= 1'b0;
            st_q.rst   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    wdt_cause_flag u_flag (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (cause_set),
        .clr_i  (clr_flag_i),
        .flag_o (cause_o)
    );

    assign irq_o     = st_q.irq;
    assign wdt_rst_o = st_q.rst;

endmodule

// File: rtl/watchdog_timer_chk.sv
module watchdog_timer_chk #(
    parameter int unsigned PULSE_CYCLES = 4
) (
    input logic clk_i,
    input logic rst_ni,
    input logic en_i,
    input logic kick_i,
    input logic clr_flag_i,
    input logic irq_o,
    input logic wdt_rst_o,
    input logic cause_o
);
    int unsigned hi_len;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        hi_len <= 0;
        else if (wdt_rst_o) hi_len <= hi_len + 1;
        else                hi_len <= 0;
    end

    // R3: a pulse is always preceded by a raised interrupt
    a_r3_irq_before_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wdt_rst_o) |-> $past(irq_o));

    // R3: the interrupt has dropped once the pulse is running
    a_r3_irq_rst_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(irq_o && wdt_rst_o));

    // R4: the pulse length is fixed unless the enable drops
    a_r4_pulse_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(wdt_rst_o) && $past(en_i)) |-> (hi_len == PULSE_CYCLES));

    a_r4_pulse_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hi_len <= PULSE_CYCLES);

    // R5: the cause flag is up whenever a pulse starts
    a_r5_flag_with_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wdt_rst_o) |-> cause_o);

    // R6: the flag only falls after a clear strobe
    a_r6_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(cause_o) |-> $past(clr_flag_i));

    // R7: a restart outside a pulse drops the interrupt
    a_r7_kick_clears_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && kick_i && !wdt_rst_o) |=> !irq_o);

    // R8: disabled means both outputs are silent
    a_r8_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (!irq_o && !wdt_rst_o));

endmodule

bind watchdog_timer watchdog_timer_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .kick_i     (kick_i),
    .clr_flag_i (clr_flag_i),
    .irq_o      (irq_o),
    .wdt_rst_o  (wdt_rst_o),
    .cause_o    (cause_o)
);

// File: tb/sim_watchdog_timer.sv
`timescale 1ns/1ps
module sim_watchdog_timer;

    // scaled parameters keep every scenario short
    localparam int unsigned BASE_EXP = 5;
    localparam int unsigned STEP_EXP = 1;
    localparam int unsigned G        = 16;
    localparam int unsigned P        = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       kick = 1'b0;
    logic       clr = 1'b0;
    logic       irq, wrst, cause;

    int n_tests = 0;
    int n_fail  = 0;
    bit cmp_on  = 1'b0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    watchdog_timer #(
        .BASE_EXP     (BASE_EXP),
        .STEP_EXP     (STEP_EXP),
        .GRACE_CYCLES (G),
        .PULSE_CYCLES (P)
    ) u0 (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .en_i       (en),
        .sel_i      (sel),
        .kick_i     (kick),
        .clr_flag_i (clr),
        .irq_o      (irq),
        .wdt_rst_o  (wrst),
        .cause_o    (cause)
    );

    function automatic int unsigned len_of(input logic [1:0] s);
        return 32'd1 << (BASE_EXP + s * STEP_EXP);
    endfunction

    task automatic chk(input string tag, input logic got, input logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // requirement-level reference: 0 run, 1 grace, 2 pulse
    int unsigned m_cnt;
    int          m_ph;
    logic        m_irq, m_rst, m_flag;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt <= 0; m_ph <= 0; m_irq <= 0; m_rst <= 0; m_flag <= 0;
        end else begin
            logic set;
            set = 1'b0;
            if (!en) begin
                m_cnt <= 0; m_ph <= 0; m_irq <= 0; m_rst <= 0;
            end else if (m_ph == 2) begin
                if (m_cnt == P - 1) begin m_ph <= 0; m_cnt <= 0; m_rst <= 0; end
                else m_cnt <= m_cnt + 1;
            end else if (kick) begin
                m_cnt <= 0; m_ph <= 0; m_irq <= 0;
            end else if (m_ph == 0) begin
                if (m_cnt + 1 >= len_of(sel)) begin m_ph <= 1; m_cnt <= 0; m_irq <= 1; end
                else m_cnt <= m_cnt + 1;
            end else begin
                if (m_cnt == G - 1) begin
                    m_ph <= 2; m_cnt <= 0; m_irq <= 0; m_rst <= 1; set = 1'b1;
                end else m_cnt <= m_cnt + 1;
            end
            if (set) m_flag <= 1'b1;
            else if (clr) m_flag <= 1'b0;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R1/R2 irq vs model", irq, m_irq);
            chk("R4 reset vs model", wrst, m_rst);
            chk("R5/R6 flag vs model", cause, m_flag);
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned L;
        void'($urandom(32'd1234));
        // R10: outputs low during reset
        cyc(3);
        chk("R10 irq in reset", irq, 1'b0);
        chk("R10 rst in reset", wrst, 1'b0);
        chk("R10 flag in reset", cause, 1'b0);
        rst_n = 1'b1;
        cyc(2);

        // R1, R2, R3, R4, R5, R9 on select 00
        L = len_of(2'd0);
        en = 1'b1; kick = 1'b1;
        cyc(1); kick = 1'b0;
        cyc(L - 1);
        chk("R1 irq not yet", irq, 1'b0);
        cyc(1);
        chk("R1 irq at timeout", irq, 1'b1);
        cyc(G - 1);
        chk("R2 irq held in grace", irq, 1'b1);
        chk("R3 no reset yet", wrst, 1'b0);
        cyc(1);
        chk("R3 reset after grace", wrst, 1'b1);
        chk("R3 irq drops at reset", irq, 1'b0);
        chk("R5 flag set", cause, 1'b1);
        cyc(P - 1);
        chk("R4 reset still high", wrst, 1'b1);
        cyc(1);
        chk("R4 reset ended", wrst, 1'b0);
        chk("R5 flag survives pulse", cause, 1'b1);
        cyc(L - 1);
        chk("R9 irq not yet", irq, 1'b0);
        cyc(1);
        chk("R9 irq after resumed count", irq, 1'b1);

        // R7: restart in grace, then restart during pulse
        kick = 1'b1; cyc(1); kick = 1'b0;
        chk("R7 kick clears irq", irq, 1'b0);
        cyc(L - 1);
        chk("R7 full interval restarts", irq, 1'b0);
        cyc(1);
        chk("R7 irq after full interval", irq, 1'b1);
        cyc(G);
        chk("R7 pulse started", wrst, 1'b1);
        kick = 1'b1; cyc(1); kick = 1'b0;
        chk("R7 kick ignored in pulse", wrst, 1'b1);
        cyc(P - 2);
        chk("R7 pulse continues", wrst, 1'b1);
        cyc(1);
        chk("R7 pulse ends on time", wrst, 1'b0);

        // R6: clear strobe
        clr = 1'b1; cyc(1); clr = 1'b0;
        chk("R6 flag cleared", cause, 1'b0);
        cyc(1);
        chk("R6 flag stays clear", cause, 1'b0);

        // R8: disabled
        en = 1'b0;
        for (int i = 0; i < int'(L + G + P + 8); i++) begin
            cyc(1);
            chk("R8 irq low when off", irq, 1'b0);
            chk("R8 rst low when off", wrst, 1'b0);
        end
        en = 1'b1;
        cyc(L - 1);
        chk("R8 re-enable counts from zero", irq, 1'b0);
        cyc(1);
        chk("R8 irq one interval after enable", irq, 1'b1);

        // R11: lower select after long count
        sel = 2'd3;
        kick = 1'b1; cyc(1); kick = 1'b0;
        cyc(int'(len_of(2'd1)) + 10);
        chk("R11 no irq on long interval", irq, 1'b0);
        sel = 2'd0;
        cyc(1);
        chk("R11 lowered select expires at once", irq, 1'b1);
        // R1 longest select
        kick = 1'b1; sel = 2'd3; cyc(1); kick = 1'b0;
        cyc(len_of(2'd3) - 1);
        chk("R1 sel 11 not yet", irq, 1'b0);
        cyc(1);
        chk("R1 sel 11 timeout", irq, 1'b1);

        // random phase against the reference
        cmp_on = 1'b1;
        for (int i = 0; i < 6000; i++) begin
            kick = ($urandom_range(0, 39) == 0);
            clr  = ($urandom_range(0, 49) == 0);
            if ($urandom_range(0, 199) == 0) sel = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 299) == 0) en = ~en;
            else if (!en && $urandom_range(0, 19) == 0) en = 1'b1;
            cyc(1);
        end
        cmp_on = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule